// File: doc/BRIEF.md
# Slot-Table Memory Bandwidth Arbiter

The block shares two memory regions among fourteen requesting clients by time division. The external region and the internal region each have a 64-entry owner table and a slot pointer. Each table entry names the client that owns that slot. When a region is given an arbitration turn, the grant goes to the owner of the current slot if that owner is requesting. If the owner is idle, the grant goes to the lowest-numbered client that is requesting. The pointer then moves to the next slot.

Software shapes the bandwidth by rewriting table entries through a single-entry write port. A client that owns k of the 64 entries is guaranteed k turns out of every 64. Slots that go unclaimed are handed to eager low-index clients.

After reset every table is filled in a rotating pattern, so all clients are served before any setup is done. The regions never share a pointer, a table or a grant.

Top module: `mem_slot_arbiter`

## Requirements
- R1: After reset, entry i of each region's table holds client i mod 14, so a turn at slot i with every client requesting grants client i mod 14.
- R2: Each region's slot pointer reads 0 after reset. It advances by exactly one on each turn of that region, wraps from 63 to 0, and holds in cycles without a turn.
- R3: During a turn, if the client named by the current slot entry is requesting, that client alone is granted in the same cycle.
- R4: During a turn, if the current slot's owner is not requesting, the lowest-numbered requesting client is granted.
- R5: No grant is raised in a cycle without a turn, nor in a turn where no client requests. Such a turn still advances the pointer.
- R6: Each region's grant vector has at most one bit set.
- R7: A write with enable high replaces exactly one entry. The entry is selected by region (0 = external, 1 = internal) and slot number, and takes the given client index. The other region's entry at the same slot number is unchanged.
- R8: A write whose client index is 14 or 15 is ignored, and the addressed entry keeps its previous owner.
- R9: A write lands at the clock edge. A turn in the same cycle at the slot being written uses the old owner, and the new owner applies the next time the pointer reaches that slot.
- R10: A turn in one region moves neither the pointer nor the grant of the other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_turn | input | 1 | Arbitration turn strobe for the external region |
| ext_req | input | 14 | Request vector of the external region, bit n for client n |
| ext_gnt | output | 14 | One-hot grant of the external region, valid in the turn cycle |
| ext_slot | output | 6 | Current slot pointer of the external region |
| int_turn | input | 1 | Arbitration turn strobe for the internal region |
| int_req | input | 14 | Request vector of the internal region |
| int_gnt | output | 14 | One-hot grant of the internal region |
| int_slot | output | 6 | Current slot pointer of the internal region |
| cfg_wr_en | input | 1 | Table entry write enable |
| cfg_wr_region | input | 1 | Region selected by the write: 0 external, 1 internal |
| cfg_wr_slot | input | 6 | Slot number written |
| cfg_wr_client | input | 4 | Client index stored; 14 and 15 are rejected |

## Verification
A table write and an arbitration turn can fall in the same cycle on the very slot being written. That case decides whether a grant comes from the old owner or the new one. The bench provokes it by issuing a turn with every client requesting while a different owner is written to the current slot. It expects the old owner's grant in that cycle. It then walks the pointer a full lap and expects the new owner. A second collision writes the internal table at the slot number the external pointer is using, to show that the write does not leak across regions.

// File: rtl/mba_pkg.sv
package mba_pkg;

    localparam int unsigned N_CLIENTS = 14;
    localparam int unsigned N_SLOTS   = 64;
    localparam int unsigned N_REGIONS = 2;
    localparam int unsigned CLI_W     = $clog2(N_CLIENTS);
    localparam int unsigned SLOT_W    = $clog2(N_SLOTS);

    typedef logic [CLI_W-1:0]     client_t;
    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [N_CLIENTS-1:0] cvec_t;

    typedef enum logic {
        REGION_EXT = 1'b0,
        REGION_INT = 1'b1
    } region_e;

    typedef struct packed {
        logic    en;
        region_e region;
        slot_t   slot;
        client_t client;
    } tbl_wr_t;

    // Rotating owner loaded into entry idx at reset.
    function automatic client_t boot_owner(input int unsigned idx);
        return client_t'(idx % N_CLIENTS);
    endfunction

endpackage

// File: rtl/mba_slot_table.sv
module mba_slot_table #(
    parameter int unsigned NCLI  = 14,
    parameter int unsigned NSLOT = 64,
    localparam int unsigned CW   = $clog2(NCLI),
    localparam int unsigned SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [CW-1:0] wr_client,
    input  logic [SW-1:0] rd_slot,
    output logic [CW-1:0] rd_owner
);

    logic [CW-1:0] owner_q [NSLOT];
    logic          wr_ok;

    assign wr_ok = wr_en && (32'(wr_client) < NCLI);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) begin
                owner_q[i] <= CW'(i % NCLI);
            end
        end else if (wr_ok) begin
            owner_q[wr_slot] <= wr_client;
        end
    end

    assign rd_owner = owner_q[rd_slot];

endmodule

// File: rtl/mba_slot_pointer.sv
module mba_slot_pointer #(
    parameter int unsigned NSLOT = 64,
    localparam int unsigned SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [SW-1:0] ptr
);

    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            if (ptr == LAST) ptr <= '0;
            else             ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/mba_grant_pick.sv
module mba_grant_pick #(
    parameter int unsigned NCLI = 14,
    localparam int unsigned CW  = $clog2(NCLI)
) (
    input  logic            turn,
    input  logic [NCLI-1:0] req,
    input  logic [CW-1:0]   owner,
    output logic [NCLI-1:0] gnt
);

    logic [NCLI-1:0] owner_bit;
    logic [NCLI-1:0] low_bit;
    logic            owner_claims;

    always_comb begin
        owner_bit    = {{(NCLI-1){1'b0}}, 1'b1} << owner;
        owner_claims = |(req & owner_bit);
        // Isolate the least significant set request bit.
        low_bit      = req & (~req + 1'b1);
        if (!turn)             gnt = '0;
        else if (owner_claims) gnt = owner_bit;
        else                   gnt = low_bit;
    end

endmodule

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter
    import mba_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_turn,
    input  logic [N_CLIENTS-1:0] ext_req,
    output logic [N_CLIENTS-1:0] ext_gnt,
    output logic [SLOT_W-1:0]    ext_slot,
    input  logic                 int_turn,
    input  logic [N_CLIENTS-1:0] int_req,
    output logic [N_CLIENTS-1:0] int_gnt,
    output logic [SLOT_W-1:0]    int_slot,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_wr_region,
    input  logic [SLOT_W-1:0]    cfg_wr_slot,
    input  logic [CLI_W-1:0]     cfg_wr_client
);

    tbl_wr_t wr;
    logic    turn_a  [N_REGIONS];
    cvec_t   req_a   [N_REGIONS];
    cvec_t   gnt_a   [N_REGIONS];
    slot_t   ptr_a   [N_REGIONS];
    client_t owner_a [N_REGIONS];

    assign wr = '{en:     cfg_wr_en,
                  region: region_e'(cfg_wr_region),
                  slot:   cfg_wr_slot,
                  client: cfg_wr_client};

    assign turn_a[0] = ext_turn;
    assign turn_a[1] = int_turn;
    assign req_a[0]  = ext_req;
    assign req_a[1]  = int_req;

    for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
        logic wr_here;
        assign wr_here = wr.en && (wr.region == region_e'(1'(r)));

        mba_slot_table #(.NCLI(N_CLIENTS), .NSLOT(N_SLOTS)) u_table (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_here),
            .wr_slot   (wr.slot),
            .wr_client (wr.client),
            .rd_slot   (ptr_a[r]),
            .rd_owner  (owner_a[r])
        );

        mba_slot_pointer #(.NSLOT(N_SLOTS)) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .advance (turn_a[r]),
            .ptr     (ptr_a[r])
        );

        mba_grant_pick #(.NCLI(N_CLIENTS)) u_pick (
            .turn  (turn_a[r]),
            .req   (req_a[r]),
            .owner (owner_a[r]),
            .gnt   (gnt_a[r])
        );
    end

    assign ext_gnt  = gnt_a[0];
    assign int_gnt  = gnt_a[1];
    assign ext_slot = ptr_a[0];
    assign int_slot = ptr_a[1];

endmodule

// File: rtl/mba_checker.sv
module mba_checker #(
    parameter int unsigned NCLI  = 14,
    parameter int unsigned NSLOT = 64,
    localparam int unsigned CW   = $clog2(NCLI),
    localparam int unsigned SW   = $clog2(NSLOT)
) (
    input logic            clk,
    input logic            rst,
    input logic            ext_turn,
    input logic [NCLI-1:0] ext_req,
    input logic [NCLI-1:0] ext_gnt,
    input logic [SW-1:0]   ext_slot,
    input logic [CW-1:0]   ext_owner,
    input logic            int_turn,
    input logic [NCLI-1:0] int_req,
    input logic [NCLI-1:0] int_gnt,
    input logic [SW-1:0]   int_slot,
    input logic [CW-1:0]   int_owner
);

    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    p_onehot_ext_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_gnt));
    p_onehot_int_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_gnt));

    p_quiet_ext_r5: assert property (@(posedge clk) disable iff (rst)
        (!ext_turn || ext_req == '0) |-> ext_gnt == '0);
    p_quiet_int_r5: assert property (@(posedge clk) disable iff (rst)
        (!int_turn || int_req == '0) |-> int_gnt == '0);

    p_owner_ext_r3: assert property (@(posedge clk) disable iff (rst)
        (ext_turn && ext_req[ext_owner]) |-> ext_gnt[ext_owner]);
    p_owner_int_r3: assert property (@(posedge clk) disable iff (rst)
        (int_turn && int_req[int_owner]) |-> int_gnt[int_owner]);

    p_only_req_ext_r4: assert property (@(posedge clk) disable iff (rst)
        (ext_gnt & ~ext_req) == '0);
    p_only_req_int_r4: assert property (@(posedge clk) disable iff (rst)
        (int_gnt & ~int_req) == '0);

    p_adv_ext_r2: assert property (@(posedge clk) disable iff (rst)
        ext_turn |=> ext_slot == (($past(ext_slot) == LAST) ? '0 : $past(ext_slot) + 1'b1));
    p_adv_int_r2: assert property (@(posedge clk) disable iff (rst)
        int_turn |=> int_slot == (($past(int_slot) == LAST) ? '0 : $past(int_slot) + 1'b1));

    p_hold_ext_r10: assert property (@(posedge clk) disable iff (rst)
        !ext_turn |=> $stable(ext_slot));
    p_hold_int_r10: assert property (@(posedge clk) disable iff (rst)
        !int_turn |=> $stable(int_slot));

    p_owner_range_r8: assert property (@(posedge clk) disable iff (rst)
        (32'(ext_owner) < NCLI) && (32'(int_owner) < NCLI));

endmodule

bind mem_slot_arbiter mba_checker #(
    .NCLI  (mba_pkg::N_CLIENTS),
    .NSLOT (mba_pkg::N_SLOTS)
) u_mba_checker (
    .clk       (clk),
    .rst       (rst),
    .ext_turn  (ext_turn),
    .ext_req   (ext_req),
    .ext_gnt   (ext_gnt),
    .ext_slot  (ext_slot),
    .ext_owner (owner_a[0]),
    .int_turn  (int_turn),
    .int_req   (int_req),
    .int_gnt   (int_gnt),
    .int_slot  (int_slot),
    .int_owner (owner_a[1])
);

// File: tb/tb_mem_slot_arbiter.sv
module tb_mem_slot_arbiter;

    localparam int NC = 14;
    localparam int NS = 64;
    localparam logic [NC-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_turn = 1'b0, int_turn = 1'b0;
    logic [NC-1:0] ext_req = '0, int_req = '0;
    logic [NC-1:0] ext_gnt, int_gnt;
    logic [5:0]    ext_slot, int_slot;
    logic          cfg_wr_en = 1'b0, cfg_wr_region = 1'b0;
    logic [5:0]    cfg_wr_slot = '0;
    logic [3:0]    cfg_wr_client = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    int mtab [2][NS];
    int mptr [2];

    always #10 clk = ~clk;

    mem_slot_arbiter dut (
        .clk(clk), .rst(rst),
        .ext_turn(ext_turn), .ext_req(ext_req), .ext_gnt(ext_gnt), .ext_slot(ext_slot),
        .int_turn(int_turn), .int_req(int_req), .int_gnt(int_gnt), .int_slot(int_slot),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_region(cfg_wr_region),
        .cfg_wr_slot(cfg_wr_slot), .cfg_wr_client(cfg_wr_client)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] expect_gnt(input logic t, input logic [NC-1:0] r, input int owner);
        if (!t || r == '0) return '0;
        if (r[owner]) return NC'(1) << owner;
        for (int k = 0; k < NC; k++) if (r[k]) return NC'(1) << k;
        return '0;
    endfunction

    // One cycle: drive at negedge, check grants and pointers, update model at edge.
    task automatic step(input logic et, input logic [NC-1:0] er,
                        input logic it, input logic [NC-1:0] ir,
                        input logic we, input logic wreg, input int ws, input int wc,
                        input string tag);
        @(negedge clk);
        ext_turn = et; ext_req = er; int_turn = it; int_req = ir;
        cfg_wr_en = we; cfg_wr_region = wreg; cfg_wr_slot = 6'(ws); cfg_wr_client = 4'(wc);
        #2;
        chk({tag, " ext slot"}, int'(ext_slot), mptr[0]);
        chk({tag, " int slot"}, int'(int_slot), mptr[1]);
        chk({tag, " ext grant"}, int'(ext_gnt), int'(expect_gnt(et, er, mtab[0][mptr[0]])));
        chk({tag, " int grant"}, int'(int_gnt), int'(expect_gnt(it, ir, mtab[1][mptr[1]])));
        @(posedge clk);
        if (et) mptr[0] = (mptr[0] + 1) % NS;
        if (it) mptr[1] = (mptr[1] + 1) % NS;
        if (we && wc < NC) mtab[wreg][ws] = wc;
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic t_reset;
        idle("R2 reset pointers / R5 no turn");
        step(0, ALL, 0, ALL, 0, 0, 0, 0, "R5 requests without turn");
        for (int i = 0; i < 16; i++) step(1, ALL, 0, '0, 0, 0, 0, 0, "R1 boot owner ext");
        for (int i = 0; i < 3; i++)  step(0, '0, 1, ALL, 0, 0, 0, 0, "R1 boot owner int");
    endtask

    task automatic t_wrap;
        while (mptr[0] != NS - 1) step(1, '0, 0, '0, 0, 0, 0, 0, "R2 advance");
        step(1, '0, 0, '0, 0, 0, 0, 0, "R2 at last slot");
        idle("R2 wrapped to zero");
        idle("R2 hold without turn");
    endtask

    task automatic t_owner;
        step(0, '0, 0, '0, 1, 0, mptr[0], 9, "R7 write owner 9");
        step(1, NC'(14'h0201), 0, '0, 0, 0, 0, 0, "R3 owner 9 over client 0");
        step(0, '0, 0, '0, 1, 1, mptr[1], 0, "R7 write int owner 0");
        step(0, '0, 1, ALL, 0, 0, 0, 0, "R3 int owner 0");
    endtask

    task automatic t_fallback;
        step(0, '0, 0, '0, 1, 0, mptr[0], 12, "R7 write owner 12");
        step(1, NC'(14'h0028), 0, '0, 0, 0, 0, 0, "R4 idle owner, lowest of 3,5");
        step(1, NC'(14'h2000), 0, '0, 0, 0, 0, 0, "R4 only client 13");
    endtask

    task automatic t_none;
        step(1, '0, 1, '0, 0, 0, 0, 0, "R5 turn without requests");
        step(0, ALL, 0, ALL, 0, 0, 0, 0, "R5 no turn");
    endtask

    task automatic t_invalid;
        int p = mptr[0];
        step(0, '0, 0, '0, 1, 0, p, 14, "R8 write client 14");
        step(0, '0, 0, '0, 1, 0, p, 15, "R8 write client 15");
        chk("R8 model unchanged", mtab[0][p], (p % NC == 14) ? 0 : mtab[0][p]);
        step(1, ALL, 0, '0, 0, 0, 0, 0, "R8 old owner kept");
    endtask

    task automatic t_same_cycle;
        int p = mptr[0];
        int oldo = mtab[0][p];
        int newo = (oldo + 5) % NC;
        step(1, ALL, 0, '0, 1, 0, p, newo, "R9 collision uses old owner");
        chk("R9 model took new owner", mtab[0][p], newo);
        while (mptr[0] != p) step(1, '0, 0, '0, 0, 0, 0, 0, "R9 lap");
        step(1, ALL, 0, '0, 0, 0, 0, 0, "R9 new owner next lap");
    endtask

    task automatic t_regions;
        int s = mptr[0];
        int c = (mtab[0][s] + 7) % NC;
        step(0, '0, 0, '0, 1, 1, s, c, "R7 int write at ext slot number");
        step(1, ALL, 0, '0, 0, 0, 0, 0, "R7 ext entry untouched");
        for (int i = 0; i < 3; i++) step(1, ALL, 0, '0, 0, 0, 0, 0, "R10 ext turns only");
        for (int i = 0; i < 3; i++) step(0, '0, 1, ALL, 0, 0, 0, 0, "R10 int turns only");
        while (mptr[1] != s) step(0, '0, 1, '0, 0, 0, 0, 0, "R7 walk int");
        step(0, '0, 1, ALL, 0, 0, 0, 0, "R7 int new owner");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        for (int r = 0; r < 2; r++) begin
            mptr[r] = 0;
            for (int i = 0; i < NS; i++) mtab[r][i] = i % NC;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wrap();
        t_owner();
        t_fallback();
        t_none();
        t_invalid();
        t_same_cycle();
        t_regions();
        idle("R6 final idle");
        finished = 1'b1;
        finish_run();
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

endmodule